// File: doc/BRIEF.md
# Ring Interconnect Channel Allocator

This block decides which data transfers may start on a ring of twelve participants. The ring is served by four unidirectional lanes: two carry data clockwise and two carry it counter-clockwise. Each participant has one request line. A request names a destination and a length in 16-byte beats, and the source is the participant's own index. For each request the allocator works out the shorter way round the ring. It then places the transfer on a lane of that direction, but only where the ring segments the path crosses are not already held on that lane. One lane can therefore carry several transfers at once, provided their paths do not overlap.

The allocator keeps a record for every participant while that participant's transfer is in flight. The record holds the lane, the segments in use, the destination and a countdown. When the countdown runs out, the segments, the lane slot and both port reservations are freed. It grants at most one transfer per clock. A rotating pointer shares the grants fairly among the requesters that are eligible. A requester holds its request until it sees either its grant or its error pulse.

Top module: `ring_xfer_alloc`

## Requirements
- R1: For source s and destination d, the clockwise distance is k = (d - s) mod 12. When 1 <= k <= 6 the transfer goes clockwise on lane 0 or 1. Otherwise it goes counter-clockwise on lane 2 or 3, over 12 - k hops. A distance of exactly six hops goes clockwise. `gnt_chan` reports the lane in the cycle the grant is shown.
- R2: Segment i is the link between positions i and (i+1) mod 12. A clockwise transfer holds segments s .. s+k-1. A counter-clockwise transfer holds segments d .. d+h-1, where h = 12 - k. All indices are taken mod 12. Lane c shows its held segments on `seg_busy[c*12 +: 12]`.
- R3: A transfer is placed on the lowest-numbered lane of its direction that has no held segment in common with the transfer's path and that carries fewer than three transfers. If no lane of that direction qualifies, the request waits.
- R4: A lane never carries more than three transfers at once.
- R5: A request whose destination equals its source, or whose destination is 12 or above, is never granted. It raises `err[s]` one cycle after it is presented, and keeps raising it every cycle it is held.
- R6: A participant is the source of at most one transfer and the destination of at most one transfer at a time. A request from a busy source, or to a busy destination, waits.
- R7: When several requests are eligible in the same cycle, the first one found when scanning upward from the rotating pointer (wrapping round) is granted. After a grant to participant w, the pointer moves to (w+1) mod 12.
- R8: A length field of N means N+1 beats, and each beat takes two clocks. A transfer holds its resources for 2(N+1) cycles after the grant is shown. `done[s]` pulses for one cycle, 2(N+1) cycles after the grant was visible.
- R9: Resources freed by a finishing transfer can be granted again on the next clock edge, so a waiting request is shown granted one cycle after the `done` pulse.
- R10: At most one grant is shown per cycle. A grant appears one cycle after an eligible request is presented, and only for a request that was present.
- R11: During reset, `gnt`, `err` and `done` are low and every lane shows no held segments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 12 | Request line per participant, held until granted or rejected |
| req_dst | input | 48 | Destination per participant, 4 bits each |
| req_len | input | 96 | Beat count minus one per participant, 8 bits each |
| gnt | output | 12 | One-cycle grant pulse, at most one bit set |
| gnt_chan | output | 2 | Lane of the grant shown on `gnt` |
| err | output | 12 | Rejection pulse for a bad destination |
| done | output | 12 | Pulse when the participant's transfer finishes |
| seg_busy | output | 48 | Held segments, 12 bits per lane |

## Verification
The hardest state to reach is a lane that is full while the segments a new request needs are still free on it. Blocking by slot count has to be told apart from blocking by overlap or by a busy port. The stimulus gets there by starting six one-hop clockwise transfers with distinct sources and destinations. These fill both clockwise lanes with three disjoint transfers each. It then offers a seventh one-hop transfer, whose segment and ports are all unused, and checks that this transfer is held back until the first lane drains. Separate sequences cover blocking by overlap, source and destination conflicts that are released into a contested round-robin choice, and an exhaustive sweep over all 132 ordered source and destination pairs on an empty ring.

// File: rtl/ring_alloc_pkg.sv
package ring_alloc_pkg;
    // Direction of travel around the ring
    typedef enum logic {
        DIR_CW  = 1'b0,
        DIR_CCW = 1'b1
    } ring_dir_e;
endpackage

// File: rtl/ring_route.sv
module ring_route
    import ring_alloc_pkg::*;
#(
    parameter int NODES  = 12,
    parameter int SRC    = 0,
    parameter int NODE_W = $clog2(NODES)
) (
    input  logic [NODE_W-1:0] dst,
    output ring_dir_e         dir,
    output logic              bad,
    output logic [NODES-1:0]  seg_mask
);
    localparam int HALF = NODES / 2;

    always_comb begin
        int k;
        int h;
        int start;
        k   = (int'(dst) + NODES - SRC) % NODES;
        bad = (int'(dst) >= NODES) || (k == 0);
        if (k <= HALF) begin
            dir   = DIR_CW;
            h     = k;
            start = SRC;
        end else begin
            dir   = DIR_CCW;
            h     = NODES - k;
            start = int'(dst) % NODES;
        end
        for (int i = 0; i < NODES; i++) begin
            int off;
            off         = (i + NODES - start) % NODES;
            seg_mask[i] = !bad && (off < h);
        end
    end
endmodule

// File: rtl/ring_rr_pick.sv
module ring_rr_pick #(
    parameter int N = 12,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] elig,
    input  logic [W-1:0] ptr,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int o = 0; o < N; o++) begin
            int i;
            i = (int'(ptr) + o) % N;
            if (!found && elig[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/ring_xfer_alloc.sv
module ring_xfer_alloc
    import ring_alloc_pkg::*;
#(
    parameter int NODES      = 12,
    parameter int CH_PER_DIR = 2,
    parameter int SLOTS      = 3,
    parameter int LEN_W      = 8,
    parameter int NODE_W     = $clog2(NODES),
    parameter int CH_W       = $clog2(2 * CH_PER_DIR)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NODES-1:0]               req_valid,
    input  logic [NODES*NODE_W-1:0]        req_dst,
    input  logic [NODES*LEN_W-1:0]         req_len,
    output logic [NODES-1:0]               gnt,
    output logic [CH_W-1:0]                gnt_chan,
    output logic [NODES-1:0]               err,
    output logic [NODES-1:0]               done,
    output logic [2*CH_PER_DIR*NODES-1:0]  seg_busy
);
    localparam int CHANS  = 2 * CH_PER_DIR;
    localparam int CNT_W  = LEN_W + 1;
    localparam int SLOT_W = $clog2(NODES + 1);

    typedef struct packed {
        logic              act;
        logic [CH_W-1:0]   chan;
        logic [NODE_W-1:0] dst;
        logic [NODES-1:0]  mask;
        logic [CNT_W-1:0]  cnt;
    } xfer_t;

    typedef struct packed {
        xfer_t [NODES-1:0] x;
        logic [NODE_W-1:0] rr;
        logic [NODES-1:0]  gnt;
        logic [NODES-1:0]  err;
        logic [NODES-1:0]  done;
        logic [CH_W-1:0]   gch;
    } state_t;

    state_t st_q, st_d;

    // ---------------- route per requester ----------------
    ring_dir_e        dir_w  [NODES];
    logic             bad_w  [NODES];
    logic [NODES-1:0] mask_w [NODES];
    logic [NODES-1:0] bad_v;

    for (genvar s = 0; s < NODES; s++) begin : g_route
        ring_route #(
            .NODES (NODES),
            .SRC   (s),
            .NODE_W(NODE_W)
        ) u_route (
            .dst     (req_dst[s*NODE_W +: NODE_W]),
            .dir     (dir_w[s]),
            .bad     (bad_w[s]),
            .seg_mask(mask_w[s])
        );
        assign bad_v[s] = bad_w[s];
    end

    // ---------------- occupancy of lanes and ports ----------------
    logic [NODES-1:0]  busy_c [CHANS];
    logic [SLOT_W-1:0] used_c [CHANS];
    logic [NODES-1:0]  dst_held;

    always_comb begin
        dst_held = '0;
        for (int c = 0; c < CHANS; c++) begin
            busy_c[c] = '0;
            used_c[c] = '0;
        end
        for (int s = 0; s < NODES; s++) begin
            if (st_q.x[s].act) begin
                busy_c[st_q.x[s].chan] = busy_c[st_q.x[s].chan] | st_q.x[s].mask;
                used_c[st_q.x[s].chan] = used_c[st_q.x[s].chan] + SLOT_W'(1);
                dst_held[st_q.x[s].dst] = 1'b1;
            end
        end
    end

    // ---------------- eligibility and lane choice ----------------
    logic [CH_W-1:0]  pick_ch [NODES];
    logic [NODES-1:0] elig;

    always_comb begin
        for (int s = 0; s < NODES; s++) begin
            logic fit;
            int   base;
            fit        = 1'b0;
            pick_ch[s] = '0;
            base       = (dir_w[s] == DIR_CW) ? 0 : CH_PER_DIR;
            for (int j = 0; j < CH_PER_DIR; j++) begin
                if (!fit && ((mask_w[s] & busy_c[base + j]) == '0)
                         && (used_c[base + j] < SLOT_W'(SLOTS))) begin
                    fit        = 1'b1;
                    pick_ch[s] = CH_W'(base + j);
                end
            end
            elig[s] = req_valid[s] && !bad_w[s] && !st_q.x[s].act && fit
                      && !dst_held[req_dst[s*NODE_W +: NODE_W]];
        end
    end

    logic              win_ok;
    logic [NODE_W-1:0] win;

    ring_rr_pick #(
        .N(NODES),
        .W(NODE_W)
    ) u_pick (
        .elig (elig),
        .ptr  (st_q.rr),
        .found(win_ok),
        .idx  (win)
    );

    // ---------------- next state ----------------
    always_comb begin
        st_d      = st_q;
        st_d.gnt  = '0;
        st_d.done = '0;
        st_d.gch  = '0;
        st_d.err  = req_valid & bad_v;
        for (int s = 0; s < NODES; s++) begin
            if (st_q.x[s].act) begin
                if (st_q.x[s].cnt == '0) begin
                    st_d.x[s].act = 1'b0;
                    st_d.done[s]  = 1'b1;
                end else begin
                    st_d.x[s].cnt = st_q.x[s].cnt - CNT_W'(1);
                end
            end
        end
        if (win_ok) begin
            st_d.x[win].act  = 1'b1;
            st_d.x[win].chan = pick_ch[win];
            st_d.x[win].dst  = req_dst[int'(win)*NODE_W +: NODE_W];
            st_d.x[win].mask = mask_w[win];
            st_d.x[win].cnt  = {req_len[int'(win)*LEN_W +: LEN_W], 1'b1};
            st_d.gnt[win]    = 1'b1;
            st_d.gch         = pick_ch[win];
            st_d.rr          = (int'(win) == NODES - 1) ? '0 : win + NODE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gnt      = st_q.gnt;
    assign gnt_chan = st_q.gch;
    assign err      = st_q.err;
    assign done     = st_q.done;

    for (genvar c = 0; c < CHANS; c++) begin : g_busy_out
        assign seg_busy[c*NODES +: NODES] = busy_c[c];
    end

    // ---------------- assertions ----------------
    int mask_pop [CHANS];
    int dst_pop  [NODES];

    always_comb begin
        for (int c = 0; c < CHANS; c++) mask_pop[c] = 0;
        for (int n = 0; n < NODES; n++) dst_pop[n] = 0;
        for (int s = 0; s < NODES; s++) begin
            if (st_q.x[s].act) begin
                mask_pop[st_q.x[s].chan] += $countones(st_q.x[s].mask);
                dst_pop[st_q.x[s].dst]   += 1;
            end
        end
    end

    p_one_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    for (genvar c = 0; c < CHANS; c++) begin : g_chan_chk
        // R3: transfers sharing a lane never share a segment
        p_chan_disjoint_r3: assert property (@(posedge clk) disable iff (!rst_n)
            mask_pop[c] == $countones(busy_c[c]));
        p_slot_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
            used_c[c] <= SLOT_W'(SLOTS));
    end

    for (genvar s = 0; s < NODES; s++) begin : g_node_chk
        p_bad_never_granted_r5: assert property (@(posedge clk) disable iff (!rst_n)
            gnt[s] |-> !$past(bad_v[s]));
        p_grant_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
            gnt[s] |-> $past(req_valid[s]));
        p_dst_unique_r6: assert property (@(posedge clk) disable iff (!rst_n)
            dst_pop[s] <= 1);
        p_done_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
            done[s] |-> !st_q.x[s].act);
    end
endmodule

// File: tb/ring_xfer_alloc_test.sv
`timescale 1ns/1ps
module ring_xfer_alloc_test;
    localparam int NODES = 12;
    localparam int NW    = 4;
    localparam int LW    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [NODES-1:0]    rv;
    logic [NODES*NW-1:0] rd;
    logic [NODES*LW-1:0] rl;
    logic [NODES-1:0]    gnt, err, done;
    logic [1:0]          gnt_chan;
    logic [4*NODES-1:0]  seg_busy;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  finished = 0;

    ring_xfer_alloc uut (
        .clk(clk), .rst_n(rst_n), .req_valid(rv), .req_dst(rd), .req_len(rl),
        .gnt(gnt), .gnt_chan(gnt_chan), .err(err), .done(done), .seg_busy(seg_busy)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input int s, input int d, input int len);
        rv[s]          = 1'b1;
        rd[s*NW +: NW] = NW'(d);
        rl[s*LW +: LW] = LW'(len);
    endtask

    task automatic drop(input int s);
        rv[s] = 1'b0;
    endtask

    function automatic bit exp_cw(input int s, input int d);
        return ((d - s + NODES) % NODES) <= NODES / 2;
    endfunction

    function automatic longint exp_mask(input int s, input int d);
        int k, h, start;
        longint m;
        k = (d - s + NODES) % NODES;
        if (k <= NODES / 2) begin h = k; start = s; end
        else begin h = NODES - k; start = d; end
        m = 0;
        for (int j = 0; j < h; j++) m = m | (longint'(1) << ((start + j) % NODES));
        return m;
    endfunction

    task automatic wait_done(input int s, input string tag);
        bit seen;
        seen = 0;
        for (int i = 0; i < 1000 && !seen; i++) begin
            @(negedge clk);
            if (done[s]) seen = 1;
        end
        check(seen, tag, 0, 1);
    endtask

    task automatic wait_idle();
        bit idle;
        idle = 0;
        for (int i = 0; i < 1000 && !idle; i++) begin
            @(negedge clk);
            if (seg_busy == '0) idle = 1;
        end
        @(negedge clk);
        check(idle, "R9 ring drains", longint'(seg_busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rv = '0; rd = '0; rl = '0;
        repeat (3) @(negedge clk);
        // R11: outputs quiet in reset
        check(gnt == 0 && err == 0 && done == 0, "R11 pulses in reset", longint'({gnt, err, done}), 0);
        check(seg_busy == 0, "R11 lanes empty in reset", longint'(seg_busy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2/R8/R10: every ordered pair on an empty ring
        for (int s = 0; s < NODES; s++) begin
            for (int d = 0; d < NODES; d++) begin
                if (d != s) begin
                    int     ch;
                    longint m;
                    ch = exp_cw(s, d) ? 0 : 2;
                    m  = exp_mask(s, d);
                    issue(s, d, 0);
                    @(negedge clk);
                    check(gnt == (NODES'(1) << s), "R10 grant next cycle", longint'(gnt), longint'(1) << s);
                    check(int'(gnt_chan) == ch, "R1 direction lane", longint'(gnt_chan), ch);
                    check(seg_busy == 48'(m << (ch * NODES)), "R2 segment mask", longint'(seg_busy), m << (ch * NODES));
                    drop(s);
                    @(negedge clk);
                    check(done == 0 && seg_busy != 0, "R8 held two cycles", longint'(done), 0);
                    @(negedge clk);
                    check(done == (NODES'(1) << s), "R8 done pulse", longint'(done), longint'(1) << s);
                    check(seg_busy == 0, "R9 released", longint'(seg_busy), 0);
                end
            end
        end

        // R8: multi-beat duration, N=3 -> 8 cycles
        begin
            int when;
            when = 0;
            issue(4, 7, 3);
            @(negedge clk);
            drop(4);
            for (int k = 1; k <= 12; k++) begin
                @(negedge clk);
                if (done[4] && when == 0) when = k;
            end
            check(when == 8, "R8 four-beat duration", when, 8);
        end

        // R5: bad destinations rejected
        for (int s = 0; s < NODES; s++) begin
            issue(s, s, 0);
            @(negedge clk);
            check(err == (NODES'(1) << s) && gnt == 0, "R5 self request flagged", longint'({err, gnt}), longint'(1) << (s + NODES));
            drop(s);
            @(negedge clk);
            check(err == 0 && seg_busy == 0, "R5 self request not granted", longint'(seg_busy), 0);
        end
        issue(3, 13, 0);
        @(negedge clk);
        check(err == 12'h008 && gnt == 0, "R5 out-of-range dest", longint'(err), 12'h008);
        drop(3);
        @(negedge clk);

        // R3: overlap forces second lane, third waits
        begin
            bit quiet;
            issue(0, 3, 20);
            @(negedge clk);
            check(gnt == 12'h001 && gnt_chan == 0, "R3 first on lane 0", longint'(gnt_chan), 0);
            drop(0);
            issue(1, 4, 20);
            @(negedge clk);
            check(gnt == 12'h002 && gnt_chan == 1, "R3 overlap to lane 1", longint'(gnt_chan), 1);
            drop(1);
            issue(2, 5, 0);
            quiet = 1;
            repeat (5) begin
                @(negedge clk);
                if (gnt != 0) quiet = 0;
            end
            check(quiet, "R3 overlapping request waits", 0, 1);
            wait_done(0, "R8 overlap holder done");
            @(negedge clk);
            check(gnt == 12'h004 && gnt_chan == 0, "R9 freed lane reused", longint'({gnt, gnt_chan}), {12'h004, 2'd0});
            drop(2);
            wait_idle();
        end

        // R4: both clockwise lanes full with disjoint hops
        begin
            bit quiet;
            for (int j = 0; j < 6; j++) begin
                issue(2 * j, 2 * j + 1, 40);
                @(negedge clk);
                check(gnt == (NODES'(1) << (2 * j)) && int'(gnt_chan) == (j < 3 ? 0 : 1),
                      "R4 fill lanes", longint'(gnt_chan), (j < 3 ? 0 : 1));
                drop(2 * j);
            end
            issue(1, 2, 0);
            quiet = 1;
            repeat (6) begin
                @(negedge clk);
                if (gnt != 0) quiet = 0;
            end
            check(quiet, "R4 full lanes block free path", 0, 1);
            wait_done(0, "R8 slot holder done");
            @(negedge clk);
            check(gnt == 12'h002 && gnt_chan == 0, "R4 slot reused", longint'({gnt, gnt_chan}), {12'h002, 2'd0});
            drop(1);
            wait_idle();
        end

        // R6: busy source and busy destination both wait
        begin
            bit quiet;
            issue(0, 3, 30);
            @(negedge clk);
            check(gnt == 12'h001, "R6 holder granted", longint'(gnt), 12'h001);
            drop(0);
            issue(0, 9, 0);
            issue(6, 3, 0);
            quiet = 1;
            repeat (5) begin
                @(negedge clk);
                if (gnt != 0) quiet = 0;
            end
            check(quiet, "R6 port conflicts wait", 0, 1);
            wait_done(0, "R8 port holder done");
            @(negedge clk);
            check(gnt == 12'h040 && gnt_chan == 2, "R7 pointer past 0 picks 6", longint'({gnt, gnt_chan}), {12'h040, 2'd2});
            drop(6);
            @(negedge clk);
            check(gnt == 12'h001 && gnt_chan == 2, "R6 source freed", longint'({gnt, gnt_chan}), {12'h001, 2'd2});
            drop(0);
            wait_idle();
        end

        // R7: round-robin order
        issue(5, 6, 0);
        @(negedge clk);
        check(gnt == 12'h020, "R7 lone request", longint'(gnt), 12'h020);
        drop(5);
        wait_idle();
        issue(2, 3, 0);
        issue(8, 9, 0);
        @(negedge clk);
        check(gnt == 12'h100, "R7 pointer at 6 picks 8", longint'(gnt), 12'h100);
        drop(8);
        @(negedge clk);
        check(gnt == 12'h004, "R7 then 2", longint'(gnt), 12'h004);
        drop(2);
        wait_idle();
        issue(1, 2, 0);
        issue(4, 5, 0);
        @(negedge clk);
        check(gnt == 12'h010, "R7 pointer at 3 picks 4", longint'(gnt), 12'h010);
        drop(4);
        @(negedge clk);
        check(gnt == 12'h002, "R7 then 1", longint'(gnt), 12'h002);
        drop(1);
        wait_idle();

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule